// File: doc/BRIEF.md
# UART FIFO Control with Character Timeout

This block holds the receive and transmit byte queues of a 16550-style serial port, along with the write-only control register that governs them. The host writes one control byte. That byte switches the queues between a deep buffered mode and a single-byte holding mode, empties either queue on demand, picks the receive threshold, and records a DMA signalling mode bit for request logic outside the block.

The receive shifter pushes bytes in and the host pops them out. The host pushes transmit bytes and the transmit shifter pops them. The block reports the state of the queues and raises two receive conditions for the interrupt identification logic:
- a threshold-reached flag;
- a character timeout, raised after four character times with no receive activity while data waits.

The character time is given as a number of baud-tick pulses. Emptying a queue touches only its stored bytes. The serial shift registers lie outside the block and are never touched.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the block is in single-byte mode (fifo_en=0). Both queues are empty, dma_mode=0, the threshold code is 0, and rx_trig_hit and rx_timeout are low.
- R2: Control byte layout:
  - bit 0 is enable;
  - bit 1 empties the receive queue;
  - bit 2 empties the transmit queue;
  - bit 3 is the DMA mode;
  - bits 7:6 are the threshold code.

  A write with bit 0 set loads the threshold code and the DMA mode. A write with bit 0 clear sets fifo_en=0 and leaves the threshold code and the DMA mode unchanged.
- R3: A write that changes the enable state, in either direction, empties both queues at that clock edge. A push or pop in the same cycle is discarded.
- R4: Bits 1 and 2 empty their queue only when bit 0 is also set in the same write. They are not stored: a later write without them leaves the queue contents alone. An emptying write overrides a push or pop in the same cycle.
- R5: In buffered mode each queue holds 16 bytes in arrival order. A push to a full queue is ignored and a pop from an empty queue is ignored. The count, empty and full outputs follow the occupancy. The pop data output shows the oldest byte.
- R6: In single-byte mode each queue holds at most one byte, and a push while it is occupied is ignored.
- R7: In buffered mode rx_trig_hit is high when the receive count is at least the threshold. The threshold is 1, 4, 8 or 14 bytes for code 0, 1, 2 or 3.
- R8: In buffered mode rx_timeout rises once 4*char_ticks baud ticks have been counted while the receive queue is non-empty with no push or pop.
- R9: An accepted receive push or pop, or emptying the receive queue, restarts the timeout count and drops rx_timeout on the next cycle. The count is held at zero while the receive queue is empty.
- R10: In single-byte mode rx_trig_hit and rx_timeout stay low.
- R11: dma_mode presents the stored DMA mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| baud_tick | input | 1 | One pulse per baud tick |
| char_ticks | input | CTW | Baud ticks per character time |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | DW | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | DW | Oldest received byte |
| rx_count | output | clog2(DEPTH+1) | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_push_data | input | DW | Transmit byte |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | DW | Oldest transmit byte |
| tx_count | output | clog2(DEPTH+1) | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| fifo_en | output | 1 | Buffered mode active |
| dma_mode | output | 1 | Stored DMA mode bit |
| rx_trig_hit | output | 1 | Receive threshold reached |
| rx_timeout | output | 1 | Character timeout pending |

## Verification
Two functions can meet in the same cycle:
- a control write that empties a queue, either by a flush bit or by a mode change;
- a push or pop on that same queue.

The bench issues such writes in the very cycle that a byte is pushed or popped, and expects the queue to be empty afterwards with the pushed byte gone. A second collision pairs a restarting push against a baud tick that would otherwise reach the timeout limit. A behavioural queue model is compared with every output on each clock, which judges both collisions.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int CFG_EN      = 0;
  localparam int CFG_RXCLR   = 1;
  localparam int CFG_TXCLR   = 2;
  localparam int CFG_DMA     = 3;
  localparam int CFG_TRIG_LO = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  function automatic int unsigned trig_level(input trig_sel_e s);
    case (s)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import ufc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  output logic      fifo_en,
  output trig_sel_e trig_sel,
  output logic      dma_mode,
  output logic      rx_clr,
  output logic      tx_clr
);
  logic      en_q, en_d;
  logic      dma_q, dma_d;
  trig_sel_e trig_q, trig_d;
  logic      mode_chg;
  logic      unused_bits;

  assign unused_bits = ^wr_data[5:4];

  always_comb begin
    en_d   = en_q;
    dma_d  = dma_q;
    trig_d = trig_q;
    if (wr_en) begin
      en_d = wr_data[CFG_EN];
      if (wr_data[CFG_EN]) begin
        dma_d  = wr_data[CFG_DMA];
        trig_d = trig_sel_e'(wr_data[CFG_TRIG_LO +: 2]);
      end
    end
  end

  assign mode_chg = wr_en && (wr_data[CFG_EN] != en_q);
  assign rx_clr   = mode_chg || (wr_en && wr_data[CFG_EN] && wr_data[CFG_RXCLR]);
  assign tx_clr   = mode_chg || (wr_en && wr_data[CFG_EN] && wr_data[CFG_TXCLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= TRIG_1;
    end else if (wr_en) begin
      en_q   <= en_d;
      dma_q  <= dma_d;
      trig_q <= trig_d;
    end
  end

  assign fifo_en  = en_q;
  assign dma_mode = dma_q;
  assign trig_sel = trig_q;

  // R2: a write without enable keeps the threshold and DMA fields
  p_fields_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CFG_EN]) |=> (trig_sel == $past(trig_sel)) && (dma_mode == $past(dma_mode)));
endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign push_ok = push && (cnt_q < cap);
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = ptr_inc(wr_q);
      if (pop_ok)  rd_d = ptr_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= push_data;
  end

  assign pop_data = mem[rd_q];
  assign count    = cnt_q;
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == cap);

  // R5: occupancy never exceeds the depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6: single-byte mode holds one byte at most
  p_single_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> (cnt_q <= CW'(1)));
  // R4: an emptying request leaves the queue empty
  p_clr_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/ufc_rx_timer.sv
module ufc_rx_timer #(
  parameter int CTW = 8,
  localparam int TW = CTW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           restart,
  input  logic           baud_tick,
  input  logic [CTW-1:0] char_ticks,
  output logic           expired
);
  logic [TW-1:0] cnt_q, cnt_d, limit;
  logic          reached;

  assign limit   = {char_ticks, 2'b00};
  assign reached = (cnt_q >= limit) && (char_ticks != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || restart)
      cnt_d = '0;
    else if (baud_tick && (cnt_q < limit))
      cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = arm && reached;

  // R9: a restart drops the timeout on the next cycle
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import ufc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CTW   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       baud_tick,
  input  logic [CTW-1:0]             char_ticks,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_push_data,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_empty,
  output logic                       rx_full,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_push_data,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       tx_empty,
  output logic                       tx_full,
  output logic                       fifo_en,
  output logic                       dma_mode,
  output logic                       rx_trig_hit,
  output logic                       rx_timeout
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int NQ   = 2;
  localparam int Q_RX = 0;
  localparam int Q_TX = 1;

  trig_sel_e     trig_sel;
  logic          rx_clr, tx_clr, rx_act;
  logic [NQ-1:0] q_clr, q_push, q_pop, q_empty, q_full;
  logic [DW-1:0] q_wdata [NQ];
  logic [DW-1:0] q_rdata [NQ];
  logic [CW-1:0] q_count [NQ];

  ufc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .fifo_en  (fifo_en),
    .trig_sel (trig_sel),
    .dma_mode (dma_mode),
    .rx_clr   (rx_clr),
    .tx_clr   (tx_clr)
  );

  assign q_clr[Q_RX]   = rx_clr;
  assign q_clr[Q_TX]   = tx_clr;
  assign q_push[Q_RX]  = rx_push;
  assign q_push[Q_TX]  = tx_push;
  assign q_pop[Q_RX]   = rx_pop;
  assign q_pop[Q_TX]   = tx_pop;
  assign q_wdata[Q_RX] = rx_push_data;
  assign q_wdata[Q_TX] = tx_push_data;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    ufc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (q_clr[g]),
      .single    (!fifo_en),
      .push      (q_push[g]),
      .push_data (q_wdata[g]),
      .pop       (q_pop[g]),
      .pop_data  (q_rdata[g]),
      .count     (q_count[g]),
      .empty     (q_empty[g]),
      .full      (q_full[g])
    );
  end

  assign rx_pop_data = q_rdata[Q_RX];
  assign rx_count    = q_count[Q_RX];
  assign rx_empty    = q_empty[Q_RX];
  assign rx_full     = q_full[Q_RX];
  assign tx_pop_data = q_rdata[Q_TX];
  assign tx_count    = q_count[Q_TX];
  assign tx_empty    = q_empty[Q_TX];
  assign tx_full     = q_full[Q_TX];

  assign rx_act = rx_clr || (rx_push && !rx_full) || (rx_pop && !rx_empty);

  logic tmo_raw;
  ufc_rx_timer #(.CTW(CTW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (fifo_en && !rx_empty),
    .restart    (rx_act),
    .baud_tick  (baud_tick),
    .char_ticks (char_ticks),
    .expired    (tmo_raw)
  );

  assign rx_timeout  = tmo_raw;
  assign rx_trig_hit = fifo_en && (rx_count >= CW'(trig_level(trig_sel)));

  // R3: every change of mode leaves both queues empty
  p_toggle_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != $past(fifo_en)) |-> (rx_empty && tx_empty));
  // R10: single-byte mode raises no receive conditions
  p_nonfifo_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!rx_trig_hit && !rx_timeout));
  // R8: a timeout needs waiting receive data
  p_timeout_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> !rx_empty);
endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;
  logic       clk, rst_n, cfg_we, baud_tick;
  logic [7:0] cfg_wdata, char_ticks;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_push_data, tx_push_data, rx_pop_data, tx_pop_data;
  logic [4:0] rx_count, tx_count;
  logic       rx_empty, rx_full, tx_empty, tx_full;
  logic       fifo_en, dma_mode, rx_trig_hit, rx_timeout;

  uart_fifo_ctl u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    nchk = 0, nfail = 0, ncyc = 0;
  bit    done = 0;
  string tag  = "R1";

  logic [7:0] rxq[$], txq[$];
  bit         m_en, m_dma;
  bit   [1:0] m_trig;
  int         m_tcnt;

  function automatic int thr(input bit [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int cap;
    bit chg, rxc, txc, rpu, rpo, tpu, tpo;
    cap = m_en ? 16 : 1;
    chg = cfg_we && (cfg_wdata[0] != m_en);
    rxc = chg || (cfg_we && cfg_wdata[0] && cfg_wdata[1]);
    txc = chg || (cfg_we && cfg_wdata[0] && cfg_wdata[2]);
    rpu = rx_push && rxq.size() < cap;
    rpo = rx_pop && rxq.size() > 0;
    tpu = tx_push && txq.size() < cap;
    tpo = tx_pop && txq.size() > 0;
    if (!(m_en && rxq.size() > 0) || rpu || rpo || rxc) m_tcnt = 0;
    else if (baud_tick && m_tcnt < 4 * int'(char_ticks)) m_tcnt++;
    if (rxc) rxq.delete();
    else begin
      if (rpo) void'(rxq.pop_front());
      if (rpu) rxq.push_back(rx_push_data);
    end
    if (txc) txq.delete();
    else begin
      if (tpo) void'(txq.pop_front());
      if (tpu) txq.push_back(tx_push_data);
    end
    if (cfg_we) begin
      m_en = cfg_wdata[0];
      if (cfg_wdata[0]) begin
        m_trig = cfg_wdata[7:6];
        m_dma  = cfg_wdata[3];
      end
    end
  endtask

  task automatic compare_all();
    int cap;
    bit etmo;
    cap  = m_en ? 16 : 1;
    etmo = m_en && rxq.size() > 0 && char_ticks != 0 && m_tcnt >= 4 * int'(char_ticks);
    chk("rx_count", int'(rx_count), rxq.size());
    chk("rx_empty", int'(rx_empty), int'(rxq.size() == 0));
    chk("rx_full",  int'(rx_full),  int'(rxq.size() == cap));
    chk("tx_count", int'(tx_count), txq.size());
    chk("tx_empty", int'(tx_empty), int'(txq.size() == 0));
    chk("tx_full",  int'(tx_full),  int'(txq.size() == cap));
    if (rxq.size() > 0) chk("rx_pop_data", int'(rx_pop_data), int'(rxq[0]));
    if (txq.size() > 0) chk("tx_pop_data", int'(tx_pop_data), int'(txq[0]));
    chk("fifo_en R2", int'(fifo_en), int'(m_en));
    chk("dma_mode R11", int'(dma_mode), int'(m_dma));
    chk("rx_trig_hit R7", int'(rx_trig_hit), int'(m_en && rxq.size() >= thr(m_trig)));
    chk("rx_timeout R8", int'(rx_timeout), int'(etmo));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    cfg_we  = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    ncyc++;
    baud_tick = ncyc[0];
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1; cfg_wdata = d; cyc();
  endtask

  task automatic rpush(input logic [7:0] d);
    rx_push = 1; rx_push_data = d; cyc();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; baud_tick = 0; char_ticks = 8'd2;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    rx_push_data = 0; tx_push_data = 0;
    m_en = 0; m_dma = 0; m_trig = 0; m_tcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; compare_all();
    chk("R1 reset count", int'(rx_count) + int'(tx_count), 0);

    // R2: load fields, then clear enable; fields must stay
    tag = "R2";
    wr(8'h89);
    chk("R2 dma loaded", int'(dma_mode), 1);
    wr(8'h40);
    chk("R2 dma kept", int'(dma_mode), 1);
    // R6 and R10: single-byte mode
    tag = "R6";
    rpush(8'hA1); rpush(8'hA2);
    chk("R6 single cap", int'(rx_count), 1);
    tag = "R10";
    repeat (20) cyc();
    chk("R10 no timeout", int'(rx_timeout), 0);
    // R3: enable with push in the same cycle
    tag = "R3";
    cfg_we = 1; cfg_wdata = 8'hC1; rx_push = 1; rx_push_data = 8'h55; tx_push = 1; cyc();
    chk("R3 flush on toggle", int'(rx_count), 0);
    // R5 and R7: fill past full
    tag = "R5";
    for (int i = 0; i < 18; i++) begin
      tx_push = 1; tx_push_data = 8'(i + 8'h30); rpush(8'(i + 8'h10));
    end
    chk("R5 full at 16", int'(rx_count), 16);
    tag = "R7";
    for (int i = 0; i < 4; i++) begin rx_pop = 1; cyc(); end
    chk("R7 below 14", int'(rx_trig_hit), 0);
    // R4: flush rx while pushing; tx flush while popping
    tag = "R4";
    cfg_we = 1; cfg_wdata = 8'hC3; rx_push = 1; rx_push_data = 8'h77; cyc();
    chk("R4 rx flushed", int'(rx_count), 0);
    wr(8'hC1);
    chk("R4 tx untouched", int'(tx_count), 16);
    cfg_we = 1; cfg_wdata = 8'hC5; tx_pop = 1; cyc();
    chk("R4 tx flushed", int'(tx_count), 0);
    // R8 and R9: timeout, then restart against a tick
    tag = "R8";
    rpush(8'h01); rpush(8'h02);
    repeat (20) cyc();
    chk("R8 timeout up", int'(rx_timeout), 1);
    tag = "R9";
    rx_pop = 1; cyc();
    chk("R9 cleared", int'(rx_timeout), 0);
    repeat (15) cyc();
    rpush(8'h03);
    repeat (6) cyc();
    // R3: disable while pushing
    tag = "R3";
    cfg_we = 1; cfg_wdata = 8'h00; rx_push = 1; rx_push_data = 8'h66; cyc();
    chk("R3 flush on disable", int'(rx_count), 0);
    // R11 and mixed traffic
    tag = "R11";
    wr(8'h09);
    tag = "R5";
    char_ticks = 8'd1;
    for (int i = 0; i < 4000; i++) begin
      rx_push = ($urandom % 3) == 0; rx_push_data = 8'($urandom);
      rx_pop  = ($urandom % 4) == 0;
      tx_push = ($urandom % 2) == 0; tx_push_data = 8'($urandom);
      tx_pop  = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) begin
        cfg_we = 1; cfg_wdata = 8'($urandom) | 8'(($urandom % 8) != 0);
      end
      cyc();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule